// File: doc/BRIEF.md
# Quantized Line Feed-Forward Selector

This block watches a stream of sampled, rectified and scaled line-voltage codes in millivolts. It picks one of eight discrete feed-forward levels from the peak of each line half-cycle. It presents the level index and a matching unsigned Q3.13 coefficient, which a downstream multiplier uses in place of a filtered RMS value. Because the coefficient comes from a fixed table, no line-frequency ripple reaches the multiplier through the feed-forward path.

The level rises in the cycle after any sample crosses a rising threshold. It falls only when a zero crossing has been qualified, which needs the input to stay below 700 mV for 50 microsecond ticks in a row. When the level falls, it goes to the level that the peak of the half-cycle just closed supports, judged against falling thresholds set 5% below the rising ones. A drop may skip several levels at once.

Top module: `qff_line_ff_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `ff_level` reads 1 and `ff_coef` reads 3260.
- R2: `ff_level` carries the level as the binary value 1 to 8. `ff_coef` always equals the entry of the current level, written as round(c × 8192) for c = 0.398, 0.600, 0.839, 1.156, 1.604, 2.199, 2.922 and 3.857 at levels 1 to 8 in that order. These are the values 3260, 4915, 6873, 9470, 13140, 18014, 23937 and 31597.
- R3: A valid sample v raises the level, in the cycle after it is taken, to 1 + (the number of rising thresholds ≤ v). The rising thresholds are 1000, 1200, 1400, 1650, 1950, 2250 and 2600 mV. A sample never lowers the level by itself.
- R4: A zero crossing is qualified on the 50th `us_tick` that arrives while the most recent valid sample was below 700 mV. A valid sample of 700 mV or more clears the tick count. After each qualification the count restarts from zero.
- R5: The level falls only at a qualified zero crossing. It then becomes min(current level, 1 + the number of falling thresholds ≤ the captured half-cycle peak), and the change shows one cycle after the qualifying tick. Each falling threshold is floor(rise × 95 / 100): 950, 1140, 1330, 1567, 1852, 2137 and 2470 mV.
- R6: The captured peak is the largest valid sample since the last qualified zero crossing. It restarts at each crossing. A sample taken in the crossing cycle becomes the first sample of the new half-cycle.
- R7: A half-cycle peak that is at or above the falling threshold below the current level, but under its rising threshold, leaves the level unchanged.
- R8: A single crossing may drop the level by more than one step. For example, from level 8, a half-cycle peak of 949 mV gives level 1.
- R9: When a crossing and a valid sample fall in the same cycle, the new level is the larger of the R5 result and the R3 result for that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new line sample |
| smp_mv | input | 12 | Rectified scaled line voltage in mV |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ff_level | output | 4 | Selected level, 1 to 8 |
| ff_coef | output | 16 | Level coefficient, unsigned Q3.13 |

## Verification
A qualified zero crossing and a fresh line sample can land in the same clock cycle. When they do, the downward decision must use the closing half-cycle's peak, while the new sample both raises the level and seeds the next peak. The bench provokes this by timing a 1500 mV sample into the cycle right after the 50th tick, following a low 500 mV half-cycle at level 8. It expects level 4 at once. One more crossing must then keep level 4, which proves the sample was kept as the new peak rather than discarded.

// File: rtl/qff_pkg.sv
// Shared constants and table functions for the line feed-forward selector.
// Assumes sample codes in millivolts and unsigned Q3.13 coefficients.
package qff_pkg;

    localparam int NUM_LVL   = 8;
    localparam int NUM_THR   = NUM_LVL - 1;
    localparam int LVL_W     = $clog2(NUM_LVL + 1);
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 13;

    // Rising threshold between level idx+1 and idx+2, in mV.
    function automatic int rise_mv(input int idx);
        case (idx)
            0:       return 1000;
            1:       return 1200;
            2:       return 1400;
            3:       return 1650;
            4:       return 1950;
            5:       return 2250;
            default: return 2600;
        endcase
    endfunction

    // Falling threshold: a fixed percentage of the rising one, truncated.
    function automatic int fall_mv(input int idx, input int pct);
        return (rise_mv(idx) * pct) / 100;
    endfunction

    // Coefficient of a level (1..8), rounded to nearest in Q3.13.
    function automatic int coef_q(input int lvl);
        int milli;
        case (lvl)
            1:       milli = 398;
            2:       milli = 600;
            3:       milli = 839;
            4:       milli = 1156;
            5:       milli = 1604;
            6:       milli = 2199;
            7:       milli = 2922;
            default: milli = 3857;
        endcase
        return (milli * (1 << COEF_FRAC) + 500) / 1000;
    endfunction

endpackage

// File: rtl/qff_zc_qualifier.sv
// Zero-crossing qualifier: counts microsecond ticks while the latest
// sample sits below the low-line threshold and emits a one-cycle pulse
// when the run reaches the qualifying length. Assumes us_tick is a
// single-cycle strobe; the count restarts after each pulse.
module qff_zc_qualifier #(
    parameter int SMP_W = 12,
    parameter int ZC_MV = 700,
    parameter int ZC_US = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_mv,
    input  logic             us_tick,
    output logic             zc_pulse
);
    localparam int CNT_W = $clog2(ZC_US + 1);
    localparam logic [SMP_W-1:0] LOW_MV = SMP_W'(ZC_MV);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(ZC_US - 1);

    logic             below_q;
    logic [CNT_W-1:0] cnt_q;
    logic             zc_q;

    // Track whether the newest sample is below the zero-crossing level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            below_q <= 1'b0;
        else if (smp_valid)
            below_q <= (smp_mv < LOW_MV);
    end

    // Count low-run ticks and raise the qualification pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            zc_q  <= 1'b0;
        end else begin
            zc_q <= 1'b0;
            if (smp_valid && (smp_mv >= LOW_MV)) begin
                cnt_q <= '0;
            end else if (below_q && us_tick) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    zc_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign zc_pulse = zc_q;

    AST_ZC_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        zc_q |-> ($past(us_tick) && $past(below_q)));   // R4
    AST_ZC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        zc_q |=> !zc_q);                                  // R4

endmodule

// File: rtl/qff_peak_tracker.sv
// Half-cycle peak tracker: holds the largest valid sample since the last
// qualified zero crossing. At a crossing it restarts, seeded with the
// sample of that cycle if one is present. Output is the registered peak,
// i.e. the closing half-cycle's peak during the crossing cycle.
module qff_peak_tracker #(
    parameter int SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_mv,
    input  logic             zc_pulse,
    output logic [SMP_W-1:0] peak_mv
);
    logic [SMP_W-1:0] peak_q;

    // Capture the running maximum; restart at each crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            peak_q <= '0;
        else if (zc_pulse)
            peak_q <= smp_valid ? smp_mv : '0;
        else if (smp_valid && (smp_mv > peak_q))
            peak_q <= smp_mv;
    end

    assign peak_mv = peak_q;

    AST_PEAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(zc_pulse) |-> (peak_q >= $past(peak_q)));  // R6

endmodule

// File: rtl/qff_level_ctrl.sv
// Level controller: compares each sample against the rising thresholds
// for immediate upward moves and the captured peak against the falling
// thresholds for downward moves at qualified crossings, then looks up the
// coefficient. Assumes zc_pulse and peak_mv come from the same cycle.
module qff_level_ctrl #(
    parameter int SMP_W    = 12,
    parameter int HYST_PCT = 95
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [SMP_W-1:0]           smp_mv,
    input  logic                       zc_pulse,
    input  logic [SMP_W-1:0]           peak_mv,
    output logic [qff_pkg::LVL_W-1:0]  level,
    output logic [qff_pkg::COEF_W-1:0] coef
);
    import qff_pkg::*;

    localparam logic [SMP_W-1:0] TOP_RISE = SMP_W'(rise_mv(NUM_THR - 1));

    logic [NUM_THR-1:0] rise_hit;
    logic [NUM_THR-1:0] fall_hit;
    logic [LVL_W-1:0]   up_lvl;
    logic [LVL_W-1:0]   dn_lvl;
    logic [LVL_W-1:0]   base_lvl;
    logic [LVL_W-1:0]   nxt_lvl;
    logic [LVL_W-1:0]   level_q;
    logic [COEF_W-1:0]  coef_tab [NUM_LVL];

    // Comparator bank, one rising and one falling compare per boundary.
    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
        localparam logic [SMP_W-1:0] R_MV = SMP_W'(rise_mv(gi));
        localparam logic [SMP_W-1:0] F_MV = SMP_W'(fall_mv(gi, HYST_PCT));
        assign rise_hit[gi] = smp_valid && (smp_mv >= R_MV);
        assign fall_hit[gi] = (peak_mv >= F_MV);
    end

    // Coefficient table built from the package function.
    for (genvar gl = 0; gl < NUM_LVL; gl++) begin : g_coef
        assign coef_tab[gl] = COEF_W'(coef_q(gl + 1));
    end

    // Count threshold hits into candidate levels.
    always_comb begin
        up_lvl = LVL_W'(1);
        dn_lvl = LVL_W'(1);
        for (int i = 0; i < NUM_THR; i++) begin
            up_lvl = up_lvl + LVL_W'(rise_hit[i]);
            dn_lvl = dn_lvl + LVL_W'(fall_hit[i]);
        end
    end

    // Combine the downward and upward decisions.
    always_comb begin
        base_lvl = level_q;
        if (zc_pulse && (dn_lvl < level_q))
            base_lvl = dn_lvl;
        nxt_lvl = (up_lvl > base_lvl) ? up_lvl : base_lvl;
    end

    // Hold the selected level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= LVL_W'(1);
        else
            level_q <= nxt_lvl;
    end

    assign level = level_q;
    assign coef  = coef_tab[level_q - LVL_W'(1)];

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q >= LVL_W'(1)) && (level_q <= LVL_W'(NUM_LVL)));  // R2
    AST_NO_DROP_WITHOUT_ZC: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q < $past(level_q)) |-> $past(zc_pulse));            // R5
    AST_RISE_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp_mv >= TOP_RISE)) |=> (level_q == LVL_W'(NUM_LVL)));  // R3

endmodule

// File: rtl/qff_line_ff_select.sv
// Top of the quantized line feed-forward selector. Wires the zero-crossing
// qualifier, the half-cycle peak tracker and the level controller.
// Assumes samples are already rectified and scaled, in millivolts.
module qff_line_ff_select #(
    parameter int SMP_W    = 12,
    parameter int ZC_MV    = 700,
    parameter int ZC_US    = 50,
    parameter int HYST_PCT = 95
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [SMP_W-1:0]           smp_mv,
    input  logic                       us_tick,
    output logic [qff_pkg::LVL_W-1:0]  ff_level,
    output logic [qff_pkg::COEF_W-1:0] ff_coef
);
    logic             zc_pulse;
    logic [SMP_W-1:0] peak_mv;

    qff_zc_qualifier #(
        .SMP_W (SMP_W),
        .ZC_MV (ZC_MV),
        .ZC_US (ZC_US)
    ) u_zc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_mv    (smp_mv),
        .us_tick   (us_tick),
        .zc_pulse  (zc_pulse)
    );

    qff_peak_tracker #(
        .SMP_W (SMP_W)
    ) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_mv    (smp_mv),
        .zc_pulse  (zc_pulse),
        .peak_mv   (peak_mv)
    );

    qff_level_ctrl #(
        .SMP_W    (SMP_W),
        .HYST_PCT (HYST_PCT)
    ) u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_mv    (smp_mv),
        .zc_pulse  (zc_pulse),
        .peak_mv   (peak_mv),
        .level     (ff_level),
        .coef      (ff_coef)
    );

endmodule

// File: tb/qff_line_ff_select_tb.sv
module qff_line_ff_select_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_mv = '0;
    logic        us_tick = 1'b0;
    logic [3:0]  ff_level;
    logic [15:0] ff_coef;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    int rise_t [7] = '{1000, 1200, 1400, 1650, 1950, 2250, 2600};
    int coef_m [8] = '{398, 600, 839, 1156, 1604, 2199, 2922, 3857};

    always #2 clk = ~clk;

    qff_line_ff_select u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_mv    (smp_mv),
        .us_tick   (us_tick),
        .ff_level  (ff_level),
        .ff_coef   (ff_coef)
    );

    function automatic int fall_of(input int i);
        return rise_t[i] * 95 / 100;
    endfunction

    function automatic int up_lvl(input int v);
        int l = 1;
        for (int i = 0; i < 7; i++) if (v >= rise_t[i]) l++;
        return l;
    endfunction

    function automatic int dn_lvl(input int v);
        int l = 1;
        for (int i = 0; i < 7; i++) if (v >= fall_of(i)) l++;
        return l;
    endfunction

    function automatic int exp_coef(input int l);
        return (coef_m[l-1] * 8192 + 500) / 1000;
    endfunction

    task automatic chk_lvl(input string req, input int exp_l);
        n_vec++;
        if (ff_level !== 4'(exp_l) || ff_coef !== 16'(exp_coef(exp_l))) begin
            n_bad++;
            $display("FAIL %s level=%0d coef=%0d expected level=%0d coef=%0d",
                     req, ff_level, ff_coef, exp_l, exp_coef(exp_l));
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        us_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int v);
        smp_valid = 1'b1;
        smp_mv = 12'(v);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Close a half-cycle: one low sample, then a full qualifying run.
    task automatic zero_cross();
        send(100);
        ticks(50);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog expired after %0d cycles", cyc);
                $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk_lvl("R1 reset", 1);

        // R3/R2: upward sweep across the code range, plus both sides of each threshold.
        for (int v = 0; v <= 3100; v += 25) begin
            do_reset();
            send(v);
            chk_lvl("R3 sweep", up_lvl(v));
        end
        for (int i = 0; i < 7; i++) begin
            do_reset();
            send(rise_t[i] - 1);
            chk_lvl("R3 below edge", i + 1);
            send(rise_t[i]);
            chk_lvl("R3 at edge", i + 2);
            send(500);
            chk_lvl("R3 no fall on sample", i + 2);
        end

        // R5/R8: from level 8, drop at a crossing to the level of the peak.
        for (int i = 0; i < 7; i++) begin
            for (int d = 0; d < 2; d++) begin
                int p = fall_of(i) - d;
                do_reset();
                send(2700);
                zero_cross();
                chk_lvl("R5 crossing with high peak keeps level", 8);
                send(p);
                zero_cross();
                chk_lvl("R5 R8 drop to peak level", dn_lvl(p));
            end
        end

        // R7: hysteresis band just under each rising threshold.
        for (int k = 0; k < 7; k++) begin
            do_reset();
            send(rise_t[k]);
            zero_cross();
            send(fall_of(k));
            zero_cross();
            chk_lvl("R7 peak in hysteresis band holds", k + 2);
            send(fall_of(k) - 1);
            zero_cross();
            chk_lvl("R7 peak under falling edge drops", k + 1);
        end

        // R4: 49 ticks do not qualify; 50 do.
        do_reset();
        send(2700);
        zero_cross();
        send(100);
        ticks(49);
        repeat (3) @(negedge clk);
        chk_lvl("R4 49 ticks not qualified", 8);
        ticks(1);
        chk_lvl("R4 50th tick qualifies", 1);

        // R4: a high sample clears the low run.
        do_reset();
        send(2700);
        zero_cross();
        send(100);
        ticks(30);
        send(800);
        send(100);
        ticks(30);
        chk_lvl("R4 high sample clears count", 8);
        ticks(20);
        chk_lvl("R4 fresh run of 50 qualifies", 1);

        // R4: a sustained low line keeps qualifying and decays the level.
        do_reset();
        send(2700);
        zero_cross();
        chk_lvl("R4 first crossing peak 2700", 8);
        ticks(50);
        chk_lvl("R4 restart after qualification", 1);

        // R9/R6: sample in the same cycle as the crossing pulse.
        do_reset();
        send(2700);
        zero_cross();
        send(500);
        ticks(49);
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
        send(1500);
        chk_lvl("R9 crossing and sample same cycle", 4);
        zero_cross();
        chk_lvl("R6 crossing-cycle sample seeds peak", 4);

        // R1: reset from a high level.
        send(2700);
        do_reset();
        chk_lvl("R1 reset from level 8", 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule